// File: doc/BRIEF.md
# Pausable Flash Duration Timer

This block times a single flash of a high-current LED. Software sets a flash-enable bit and supplies a 5-bit duration code. The light is on only while that bit is set and an external trigger pin is high. A remaining-time counter is loaded from the code when the enable bit rises. It counts down only in cycles where light is allowed, so one flash may be cut into several shorter pulses whose lengths add up to the programmed duration.

The counter also stops while the storage capacitor is sagging. A low-supply flag freezes it at once. After the flag clears, the counter stays frozen until a second flag reports that the capacitor has recharged to its ready level. On expiry the block drives a one-cycle request that clears the enable bit, and it pulls an active-low attention line low for a fixed number of clock cycles. A trigger pulse after expiry gives no light until the enable bit is cleared and set again.

The timer base is a prescaler of `TICK_DIV` clock cycles. Each step of the duration code is worth `STEPS_PER_CODE` ticks, so a code `c` lasts `c * STEPS_PER_CODE * TICK_DIV` counting cycles.

Top module: `flash_timer`

## Requirements
- R1: `led_on_o` is high in a cycle exactly when, in the previous cycle, the flash was armed, `flash_en_i` and `trig_i` were high, `cap_low_i` was low, no sag hold was pending, and `flash_en_i` was not making its 0-to-1 transition.
- R2: With a nonzero code `c` and the trigger held high, `led_on_o` is high for exactly `c * STEPS_PER_CODE * TICK_DIV` cycles.
- R3: Cycles with `trig_i` low freeze the remaining count. The LED-on cycles of a split flash add up to the same total as in R2.
- R4: `cap_low_i` high freezes the count and holds the LED off. The hold stays in force after `cap_low_i` falls and ends only in a cycle where `cap_ready_i` is high and `cap_low_i` is low.
- R5: On expiry, `en_clr_o` is high for exactly one cycle. That cycle is the same cycle as the last LED-on cycle.
- R6: `attn_n_o` goes low in the same cycle as `en_clr_o` and stays low for exactly `ATTN_CYCLES` cycles.
- R7: After expiry, keeping `flash_en_i` and `trig_i` high produces no LED-on cycle.
- R8: A zero duration code at the enable's 0-to-1 transition expires in the next cycle. `en_clr_o` and the attention pulse are produced, and `led_on_o` never rises.
- R9: Dropping `flash_en_i` during a flash turns the LED off. Raising it again reloads the full duration from the code.
- R10: During and right after reset, `led_on_o` and `en_clr_o` are 0 and `attn_n_o` is 1.
- R11: `dur_code_i` is sampled only at the enable's 0-to-1 transition. Later changes to it do not alter the running flash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flash_en_i | input | 1 | Flash-enable command bit |
| dur_code_i | input | 5 | Duration code, sampled when enable rises |
| trig_i | input | 1 | External trigger pin; light allowed while high |
| cap_low_i | input | 1 | Capacitor below the sag threshold |
| cap_ready_i | input | 1 | Capacitor at or above the programmed ready level |
| led_on_o | output | 1 | LED current enable |
| en_clr_o | output | 1 | One-cycle request to clear the flash-enable bit |
| attn_n_o | output | 1 | Attention line, active low, fixed-width pulse |

## Verification
Every output is registered. The LED, clear and attention results for the inputs applied at one falling edge are therefore due exactly one rising edge later. The bench drives inputs at the falling edge and compares the outputs at the next falling edge. Those outputs are checked against a cycle-level model of the requirements; the model counts the remaining time in counting cycles and does not mirror the prescaler. Totals of LED-on, clear and attention cycles are then checked for each scenario against `c * STEPS_PER_CODE * TICK_DIV`, one and `ATTN_CYCLES` respectively. The scenarios cover all 32 codes, split triggers, a supply sag, enable restart and a code change during a flash.

// File: rtl/flash_timer_pkg.sv
package flash_timer_pkg;

    localparam int unsigned FT_CODE_W = 5;

    typedef struct packed {
        logic en_prev;
        logic armed;
        logic led;
        logic clr;
    } ft_ctrl_t;

endpackage

// File: rtl/ft_prescale.sv
module ft_prescale #(
    parameter int unsigned TICK_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic tick_o
);
    generate
        if (TICK_DIV <= 1) begin : g_direct
            assign tick_o = run_i;
        end else begin : g_div
            localparam int unsigned DIV_W = $clog2(TICK_DIV);
            localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);

            logic [DIV_W-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (clear_i) begin
                    cnt_d = '0;
                end else if (run_i) begin
                    cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick_o = run_i && (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/ft_remain.sv
module ft_remain
    import flash_timer_pkg::*;
#(
    parameter int unsigned STEPS_PER_CODE = 4,
    parameter int unsigned REM_W = $clog2(((1 << FT_CODE_W) - 1) * STEPS_PER_CODE + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [FT_CODE_W-1:0] code_i,
    input  logic                 dec_i,
    output logic                 last_o
);
    localparam logic [REM_W-1:0] STEPS_V = REM_W'(STEPS_PER_CODE);

    logic [REM_W-1:0] rem_d, rem_q;

    always_comb begin
        rem_d = rem_q;
        if (load_i) begin
            rem_d = REM_W'(code_i) * STEPS_V;
        end else if (dec_i && rem_q != '0) begin
            rem_d = rem_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= rem_d;
    end

    assign last_o = (rem_q == REM_W'(1));

    // a tick must never arrive when nothing remains
    assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i) |-> (rem_q != '0));
endmodule

// File: rtl/ft_attn.sv
module ft_attn #(
    parameter int unsigned ATTN_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic attn_n_o
);
    localparam int unsigned ATTN_W = $clog2(ATTN_CYCLES + 1);

    logic [ATTN_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (fire_i) begin
            cnt_d = ATTN_W'(ATTN_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign attn_n_o = (cnt_q == '0);

    assert_attn_follows_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> !attn_n_o);
endmodule

// File: rtl/ft_sag.sv
module ft_sag (
    input  logic clk,
    input  logic rst_n,
    input  logic low_i,
    input  logic ready_i,
    output logic sag_o
);
    logic sag_d, sag_q;

    always_comb begin
        sag_d = sag_q;
        if (low_i)        sag_d = 1'b1;
        else if (ready_i) sag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sag_q <= 1'b0;
        else        sag_q <= sag_d;
    end

    assign sag_o = sag_q;

    assert_sag_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        low_i |=> sag_o);
    assert_sag_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sag_o && !low_i && !ready_i) |=> sag_o);
endmodule

// File: rtl/flash_timer.sv
module flash_timer
    import flash_timer_pkg::*;
#(
    parameter int unsigned TICK_DIV       = 16,
    parameter int unsigned STEPS_PER_CODE = 4,
    parameter int unsigned ATTN_CYCLES    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flash_en_i,
    input  logic [4:0] dur_code_i,
    input  logic       trig_i,
    input  logic       cap_low_i,
    input  logic       cap_ready_i,
    output logic       led_on_o,
    output logic       en_clr_o,
    output logic       attn_n_o
);
    ft_ctrl_t ctl_d, ctl_q;

    logic rise, hold, active, tick, last, sag;
    logic expire_run, expire_zero, expire;

    ft_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (rise),
        .run_i   (active),
        .tick_o  (tick)
    );

    ft_remain #(.STEPS_PER_CODE(STEPS_PER_CODE)) u_rem (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (rise),
        .code_i (dur_code_i),
        .dec_i  (tick),
        .last_o (last)
    );

    ft_sag u_sag (
        .clk     (clk),
        .rst_n   (rst_n),
        .low_i   (cap_low_i),
        .ready_i (cap_ready_i),
        .sag_o   (sag)
    );

    ft_attn #(.ATTN_CYCLES(ATTN_CYCLES)) u_attn (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (expire),
        .attn_n_o (attn_n_o)
    );

    always_comb begin
        rise        = flash_en_i && !ctl_q.en_prev;
        hold        = sag || cap_low_i;
        active      = ctl_q.armed && flash_en_i && trig_i && !hold && !rise;
        expire_run  = tick && last;
        expire_zero = rise && (dur_code_i == '0);
        expire      = expire_run || expire_zero;

        ctl_d         = ctl_q;
        ctl_d.en_prev = flash_en_i;
        if (!flash_en_i)     ctl_d.armed = 1'b0;
        else if (rise)       ctl_d.armed = (dur_code_i != '0);
        else if (expire_run) ctl_d.armed = 1'b0;
        ctl_d.led = active;
        ctl_d.clr = expire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign led_on_o = ctl_q.led;
    assign en_clr_o = ctl_q.clr;

    assert_led_needs_trigger_R1: assert property (@(posedge clk) disable iff (!rst_n)
        led_on_o |-> $past(trig_i && flash_en_i));
    assert_sag_blocks_led_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cap_low_i) |-> !led_on_o);
    assert_clr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr_o |=> !en_clr_o);
    assert_dark_after_expiry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr_o |=> !led_on_o);
endmodule

// File: tb/flash_timer_tb.sv
module flash_timer_tb;
    localparam int PERIOD = 10;
    localparam int DIV    = 4;
    localparam int STEPS  = 2;
    localparam int ATTN   = 5;
    localparam int UNIT   = DIV * STEPS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flash_en = 1'b0, trig = 1'b0, cap_low = 1'b0, cap_ready = 1'b0;
    logic [4:0] code = '0;
    logic led_on_o, en_clr_o, attn_n_o;

    int checks = 0, fails = 0;
    int cnt_led = 0, cnt_clr = 0, cnt_attn = 0, cnt_win = 0;
    bit win = 1'b0;

    // cycle-level expectations
    logic m_prev_en = 0, m_armed = 0, m_sag = 0;
    int   m_rem = 0, m_attn = 0;
    logic exp_led = 0, exp_clr = 0, exp_attn_n = 1;

    flash_timer #(.TICK_DIV(DIV), .STEPS_PER_CODE(STEPS), .ATTN_CYCLES(ATTN)) u_dut (
        .clk(clk), .rst_n(rst_n), .flash_en_i(flash_en), .dur_code_i(code),
        .trig_i(trig), .cap_low_i(cap_low), .cap_ready_i(cap_ready),
        .led_on_o(led_on_o), .en_clr_o(en_clr_o), .attn_n_o(attn_n_o));

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic cyc(input logic en, input logic [4:0] c, input logic tg,
                       input logic lo, input logic rd);
        logic rise, act, expire;
        @(negedge clk);
        check(led_on_o === exp_led, "R1 led per cycle", led_on_o, exp_led);
        check(en_clr_o === exp_clr && attn_n_o === exp_attn_n, "R5/R6 clr+attn per cycle",
              {en_clr_o, attn_n_o}, {exp_clr, exp_attn_n});
        if (led_on_o) cnt_led++;
        if (en_clr_o) cnt_clr++;
        if (!attn_n_o) cnt_attn++;
        if (win && led_on_o) cnt_win++;
        flash_en = en; code = c; trig = tg; cap_low = lo; cap_ready = rd;
        rise   = en && !m_prev_en;
        act    = m_armed && en && tg && !(m_sag || lo) && !rise;
        expire = (rise && c == 0) || (act && m_rem == 1);
        exp_led = act;
        exp_clr = expire;
        m_attn  = expire ? ATTN : (m_attn > 0 ? m_attn - 1 : 0);
        exp_attn_n = (m_attn == 0);
        if (!en) m_armed = 0;
        else if (rise) m_armed = (c != 0);
        else if (act && m_rem == 1) m_armed = 0;
        if (rise) m_rem = c * UNIT;
        else if (act) m_rem = m_rem - 1;
        m_sag = lo ? 1'b1 : (rd ? 1'b0 : m_sag);
        m_prev_en = en;
    endtask

    task automatic clr_counts();
        cnt_led = 0; cnt_clr = 0; cnt_attn = 0; cnt_win = 0;
    endtask

    initial begin
        #(PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(led_on_o === 1'b0 && en_clr_o === 1'b0 && attn_n_o === 1'b1,
              "R10 reset state", {led_on_o, en_clr_o, attn_n_o}, 3'b001);
        rst_n = 1'b1;
        cyc(0, 0, 0, 0, 1);
        check(led_on_o === 1'b0 && attn_n_o === 1'b1, "R10 after reset",
              {led_on_o, attn_n_o}, 1);

        // all codes, steady trigger; tail covers R7
        for (int c = 0; c < 32; c++) begin
            cyc(0, 5'(c), 0, 0, 1); cyc(0, 5'(c), 0, 0, 1);
            clr_counts();
            for (int i = 0; i < c * UNIT + ATTN + 25; i++) cyc(1, 5'(c), 1, 0, 1);
            check(cnt_led == c * UNIT, (c == 0) ? "R8 zero code no light" : "R2 total on",
                  cnt_led, c * UNIT);
            check(cnt_clr == 1, "R5 single clear", cnt_clr, 1);
            check(cnt_attn == ATTN, "R6 attention width", cnt_attn, ATTN);
        end

        // R7: still enabled and triggered after expiry
        clr_counts();
        for (int i = 0; i < 30; i++) cyc(1, 5'd4, 1, 0, 1);
        check(cnt_led == 0, "R7 no light after expiry", cnt_led, 0);

        // R3: split trigger
        for (int k = 0; k < 3; k++) begin
            int c;
            c = (k == 0) ? 5 : (k == 1) ? 17 : 31;
            cyc(0, 5'(c), 0, 0, 1);
            clr_counts();
            for (int i = 0; i < 3 * c * UNIT + ATTN + 10; i++)
                cyc(1, 5'(c), ((i % 5) < 2), 0, 1);
            check(cnt_led == c * UNIT, "R3 split total", cnt_led, c * UNIT);
            check(cnt_clr == 1, "R3 split single expiry", cnt_clr, 1);
        end

        // R4: sag hold until ready
        cyc(0, 3, 0, 0, 1);
        clr_counts();
        for (int i = 0; i < 60; i++) begin
            win = (i >= 8 && i <= 19);
            cyc(1, 3, 1, (i >= 6 && i < 9), !(i >= 6 && i < 19));
        end
        win = 0;
        check(cnt_win == 0, "R4 dark during sag hold", cnt_win, 0);
        check(cnt_led == 3 * UNIT, "R4 total after recharge", cnt_led, 3 * UNIT);

        // R9: enable dropped then raised reloads
        cyc(0, 2, 0, 0, 1);
        clr_counts();
        for (int i = 0; i < 10; i++) cyc(1, 2, 1, 0, 1);
        for (int i = 0; i < 3; i++) cyc(0, 2, 1, 0, 1);
        check(cnt_led == 9 && cnt_clr == 0, "R9 partial before drop", cnt_led, 9);
        clr_counts();
        for (int i = 0; i < 2 * UNIT + ATTN + 5; i++) cyc(1, 2, 1, 0, 1);
        check(cnt_led == 2 * UNIT, "R9 full reload", cnt_led, 2 * UNIT);

        // R11: code change mid-flash ignored
        cyc(0, 4, 0, 0, 1);
        clr_counts();
        for (int i = 0; i < 3; i++) cyc(1, 4, 1, 0, 1);
        for (int i = 0; i < 9 * UNIT + 10; i++) cyc(1, 9, 1, 0, 1);
        check(cnt_led == 4 * UNIT, "R11 code latched at start", cnt_led, 4 * UNIT);

        cyc(0, 0, 0, 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule